// File: doc/BRIEF.md
# Programmable Interrupt Vector Responder

This block raises interrupts for an 8-bit CPU that has three interrupt response modes. It has two request sources: a serial-receive pulse and a periodic tick. Each source can be enabled on its own. A rising edge on an enabled source sets a pending flag for that source. The block pulls the CPU's active-low interrupt line low while any enabled flag is pending.

The block watches the CPU strobes for an interrupt-acknowledge cycle. During that cycle it drives a host-programmed byte onto the data bus. In the opcode-fetch mode the CPU executes that byte, usually as a restart instruction. In the vectored mode the byte is the low half of a table address, and the CPU supplies the high half. In the fixed-restart mode the CPU ignores the byte.

The host programs the block through a command stream with `cmd_valid`/`cmd_ready`. Each command carries a code and one data byte. The block never applies back-pressure: `cmd_ready` is always high, and every beat with `cmd_valid` high is taken on the clock edge it is presented at.

Top module: `irq_vector_responder`

## Requirements
- R1: After reset, `int_n` is 1, `bus_oe` is 0, both enables are off and the vector byte is 0xFF (restart to 0x38, so the opcode-fetch and fixed-restart modes behave alike).
- R2: A 0→1 edge on `rx_req` or `tick_req` sets that source's pending flag only if the source is enabled at that edge. An edge seen while the source is disabled is dropped, and enabling the source later does not raise `int_n`.
- R3: A source that stays high causes no further request. Only a new 0→1 edge sets the flag again.
- R4: Command code 0x0E writes the enables. Data bit 0 enables serial receive and data bit 1 enables the tick.
- R5: Command code 0x0F writes the 8-bit vector byte. Any other code changes neither the enables nor the vector.
- R6: An acknowledge cycle is `iorq_n`=0 and `m1_n`=0 with `rd_n`=1 and `wr_n`=1. During it, `bus_oe` is 1 and `bus_dout` equals the vector byte in the same cycle. At all other times (I/O reads and writes, opcode fetches, idle) `bus_oe` is 0.
- R7: When an acknowledge cycle ends, the pending flag of the source it served is cleared on that clock edge. If no other enabled flag is pending, `int_n` returns to 1 right after that edge.
- R8: If both sources are pending and enabled when an acknowledge begins, serial receive is served and the tick stays pending.
- R9: `int_n` is 0 exactly while at least one pending flag has its enable set. Clearing an enable masks its flag without clearing it, and setting the enable again restores the request.
- R10: `cmd_ready` is always 1 outside reset, so the command stream never stalls.
- R11: A new enabled edge on a source while its acknowledge is ending wins over the clear, so the request is not lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| iorq_n | input | 1 | CPU I/O request strobe, active low |
| m1_n | input | 1 | CPU machine-cycle-one strobe, active low |
| rd_n | input | 1 | CPU read strobe, active low |
| wr_n | input | 1 | CPU write strobe, active low |
| rx_req | input | 1 | Raw serial-receive request |
| tick_req | input | 1 | Raw periodic tick request |
| cmd_valid | input | 1 | Host command beat valid |
| cmd_ready | output | 1 | Host command accept (always high) |
| cmd_code | input | 8 | Host command code |
| cmd_data | input | 8 | Host command data byte |
| int_n | output | 1 | Interrupt line to the CPU, active low |
| bus_dout | output | 8 | Byte for the data bus driver |
| bus_oe | output | 1 | Data bus driver enable |

## Verification
A lost or stuck pending flag shows on `int_n` one clock after the edge, acknowledge end or enable write that should have changed it. The bench compares `int_n` with its own model on every cycle, so such a fault is caught at once. A wrong priority choice only shows later: the wrong flag survives the acknowledge, and then masking one source leaves the line in the wrong state. A corrupted vector register or a wrong drive window shows in the same cycle as the acknowledge strobes, as a wrong `bus_dout` or `bus_oe`.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int N_SRC = 2;
  localparam int SRC_RX = 0;
  localparam int SRC_TICK = 1;
  localparam logic [7:0] CMD_SET_EN  = 8'h0E;
  localparam logic [7:0] CMD_SET_VEC = 8'h0F;
  localparam logic [7:0] VEC_RESET   = 8'hFF;
endpackage

// File: rtl/irqv_cmd_regs.sv
module irqv_cmd_regs
  import irqv_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter int NS = N_SRC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [CW-1:0] cmd_code,
  input  logic [DW-1:0] cmd_data,
  output logic [NS-1:0] en,
  output logic [DW-1:0] vec
);
  logic hit_en, hit_vec;

  assign hit_en  = cmd_valid && (cmd_code == CW'(CMD_SET_EN));
  assign hit_vec = cmd_valid && (cmd_code == CW'(CMD_SET_VEC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= '0;
      vec <= DW'(VEC_RESET);
    end else begin
      if (hit_en)  en  <= cmd_data[NS-1:0];
      if (hit_vec) vec <= cmd_data;
    end
  end
endmodule

// File: rtl/irqv_pend.sv
module irqv_pend #(
  parameter int NS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NS-1:0] src_raw,
  input  logic [NS-1:0] en,
  input  logic [NS-1:0] clr,
  output logic [NS-1:0] pend
);
  for (genvar g = 0; g < NS; g++) begin : g_src
    logic prev_q, rise;
    assign rise = src_raw[g] & ~prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        prev_q  <= 1'b0;
        pend[g] <= 1'b0;
      end else begin
        prev_q  <= src_raw[g];
        // a fresh enabled edge outranks the clear of the same flag
        pend[g] <= (pend[g] & ~clr[g]) | (rise & en[g]);
      end
    end
  end
endmodule

// File: rtl/irqv_ack_ctl.sv
module irqv_ack_ctl #(
  parameter int NS = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iorq_n,
  input  logic          m1_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [NS-1:0] pend,
  input  logic [NS-1:0] en,
  output logic          ack_now,
  output logic [NS-1:0] clr
);
  logic          ack_q;
  logic [NS-1:0] sel_q;
  logic [NS-1:0] pick;
  logic          found;

  assign ack_now = ~iorq_n & ~m1_n & rd_n & wr_n;

  // lowest index (serial receive) takes precedence
  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = 0; i < NS; i++) begin
      if (!found && pend[i] && en[i]) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      sel_q <= '0;
    end else begin
      ack_q <= ack_now;
      if (ack_now && !ack_q)      sel_q <= pick;
      else if (!ack_now && ack_q) sel_q <= '0;
    end
  end

  assign clr = (!ack_now && ack_q) ? sel_q : '0;
endmodule

// File: rtl/irq_vector_responder.sv
module irq_vector_responder
  import irqv_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iorq_n,
  input  logic          m1_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          rx_req,
  input  logic          tick_req,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic [CW-1:0] cmd_code,
  input  logic [DW-1:0] cmd_data,
  output logic          int_n,
  output logic [DW-1:0] bus_dout,
  output logic          bus_oe
);
  logic [N_SRC-1:0] en_w, pend_w, clr_w, raw_w;
  logic [DW-1:0]    vec_w;
  logic             ack_w;

  assign raw_w[SRC_RX]   = rx_req;
  assign raw_w[SRC_TICK] = tick_req;

  irqv_cmd_regs #(.DW(DW), .CW(CW), .NS(N_SRC)) u_regs (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_data(cmd_data), .en(en_w), .vec(vec_w)
  );

  irqv_pend #(.NS(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .src_raw(raw_w), .en(en_w), .clr(clr_w),
    .pend(pend_w)
  );

  irqv_ack_ctl #(.NS(N_SRC)) u_ack (
    .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .m1_n(m1_n), .rd_n(rd_n),
    .wr_n(wr_n), .pend(pend_w), .en(en_w), .ack_now(ack_w), .clr(clr_w)
  );

  assign cmd_ready = 1'b1;
  assign int_n     = ~|(pend_w & en_w);
  assign bus_oe    = ack_w;
  assign bus_dout  = vec_w;
endmodule

// File: rtl/irqv_checker.sv
module irqv_checker
  import irqv_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             iorq_n,
  input logic             m1_n,
  input logic             rx_req,
  input logic             tick_req,
  input logic             cmd_valid,
  input logic [CW-1:0]    cmd_code,
  input logic [DW-1:0]    cmd_data,
  input logic             int_n,
  input logic             bus_oe,
  input logic [DW-1:0]    vec,
  input logic [N_SRC-1:0] clr
);
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (iorq_n || m1_n) |-> !bus_oe); // R6

  AST_VEC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == CW'(CMD_SET_VEC)) |=> (vec == $past(cmd_data))); // R5

  AST_INT_FALL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_n) |-> $past(rx_req || tick_req || cmd_valid)); // R2

  AST_INT_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_n) |-> ($past(cmd_valid) || $past(!iorq_n && !m1_n, 2))); // R7

  AST_CLR_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (|clr) |-> $past(!iorq_n && !m1_n)); // R7

  AST_SINGLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr)); // R8
endmodule

bind irq_vector_responder irqv_checker #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .m1_n(m1_n), .rx_req(rx_req),
  .tick_req(tick_req), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .cmd_data(cmd_data), .int_n(int_n), .bus_oe(bus_oe), .vec(vec_w), .clr(clr_w)
);

// File: tb/irq_vector_responder_tb.sv
`timescale 1ns/1ps
module irq_vector_responder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       iorq_n = 1'b1, m1_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic       rx_req = 1'b0, tick_req = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [7:0] cmd_code = 8'h00, cmd_data = 8'h00;
  logic       cmd_ready, int_n, bus_oe;
  logic [7:0] bus_dout;

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model state
  logic [1:0] m_pend = 2'b00, m_en = 2'b00, m_sel = 2'b00;
  logic [7:0] m_vec = 8'hFF;
  logic       m_rx_prev = 0, m_tick_prev = 0, m_ack_prev = 0;

  always #2.5 clk = ~clk;

  irq_vector_responder u_dut (
    .clk(clk), .rst_n(rst_n), .iorq_n(iorq_n), .m1_n(m1_n), .rd_n(rd_n),
    .wr_n(wr_n), .rx_req(rx_req), .tick_req(tick_req), .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready), .cmd_code(cmd_code), .cmd_data(cmd_data),
    .int_n(int_n), .bus_dout(bus_dout), .bus_oe(bus_oe)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic is_ack();
    return !iorq_n && !m1_n && rd_n && wr_n;
  endfunction

  function automatic logic [1:0] pick_src(input logic [1:0] p, input logic [1:0] e);
    if (p[0] && e[0]) return 2'b01;
    if (p[1] && e[1]) return 2'b10;
    return 2'b00;
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // one clock: model update at the edge, compare outputs at the falling edge
  task automatic cycle();
    logic [1:0] rise, clr;
    logic a;
    @(posedge clk);
    a    = is_ack();
    rise = {tick_req & ~m_tick_prev, rx_req & ~m_rx_prev};
    clr  = (!a && m_ack_prev) ? m_sel : 2'b00;
    if (a && !m_ack_prev)      m_sel = pick_src(m_pend, m_en);
    else if (!a && m_ack_prev) m_sel = 2'b00;
    m_pend = (m_pend & ~clr) | (rise & m_en);
    if (cmd_valid && cmd_code == 8'h0E) m_en  = cmd_data[1:0];
    if (cmd_valid && cmd_code == 8'h0F) m_vec = cmd_data;
    m_rx_prev = rx_req; m_tick_prev = tick_req; m_ack_prev = a;
    @(negedge clk);
    chk(int_n == ~|(m_pend & m_en), "R9 int line vs model", int_n, ~|(m_pend & m_en));
    chk(bus_oe == is_ack(), "R6 drive window", bus_oe, is_ack());
    if (is_ack()) chk(bus_dout == m_vec, "R6 vector byte", bus_dout, m_vec);
    chk(cmd_ready == 1'b1, "R10 ready", cmd_ready, 1);
  endtask

  task automatic send_cmd(input logic [7:0] code, input logic [7:0] data);
    cmd_valid = 1; cmd_code = code; cmd_data = data;
    cycle();
    cmd_valid = 0;
  endtask

  task automatic pulse(input bit tick, input bit rx);
    if (rx) rx_req = 1;
    if (tick) tick_req = 1;
    cycle();
    if (rx) rx_req = 0;
    if (tick) tick_req = 0;
    cycle();
  endtask

  task automatic set_strobes(input logic io, input logic m1, input logic rd, input logic wr);
    iorq_n = io; m1_n = m1; rd_n = rd; wr_n = wr;
  endtask

  task automatic do_ack(input int len);
    set_strobes(0, 0, 1, 1);
    for (int k = 0; k < len; k++) cycle();
    set_strobes(1, 1, 1, 1);
    cycle();
  endtask

  initial begin
    #(5.0 * 150000);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(int_n == 1, "R1 int_n in reset", int_n, 1);
    chk(bus_oe == 0, "R1 bus_oe in reset", bus_oe, 0);
    rst_n = 1;
    cycle();
    // R1: default vector on an acknowledge
    set_strobes(0, 0, 1, 1);
    @(negedge clk);
    chk(bus_oe == 1 && bus_dout == 8'hFF, "R1 reset vector", bus_dout, 8'hFF);
    set_strobes(1, 1, 1, 1);
    cycle(); cycle();

    // R2: edge while disabled is lost
    pulse(0, 1);
    send_cmd(8'h0E, 8'h01);
    cycle();
    chk(int_n == 1, "R2 disabled edge dropped", int_n, 1);

    // R4: bit0 enables serial receive
    pulse(0, 1);
    chk(int_n == 0, "R4 rx enabled raises int", int_n, 0);
    // R7: released right after acknowledge
    do_ack(2);
    chk(int_n == 1, "R7 flag cleared at ack end", int_n, 1);

    // R3: held level does not retrigger
    rx_req = 1; cycle();
    chk(int_n == 0, "R3 first edge", int_n, 0);
    do_ack(1);
    repeat (3) cycle();
    chk(int_n == 1, "R3 held high no retrigger", int_n, 1);
    rx_req = 0; cycle();

    // R8 and R9: both pending, rx first, tick masked then restored
    send_cmd(8'h0E, 8'h03);
    pulse(1, 1);
    do_ack(1);
    chk(int_n == 0, "R8 tick still pending", int_n, 0);
    send_cmd(8'h0E, 8'h01);
    chk(int_n == 1, "R8 rx served first", int_n, 1);
    send_cmd(8'h0E, 8'h03);
    chk(int_n == 0, "R9 mask restored", int_n, 0);
    do_ack(1);
    chk(int_n == 1, "R9 all served", int_n, 1);

    // R5: vector write, foreign code ignored
    send_cmd(8'h0F, 8'hC7);
    send_cmd(8'h33, 8'h11);
    set_strobes(0, 0, 1, 1);
    @(negedge clk);
    chk(bus_dout == 8'hC7, "R5 vector kept", bus_dout, 8'hC7);
    set_strobes(1, 1, 1, 1);
    cycle();
    pulse(1, 0);
    chk(int_n == 0, "R5 enables kept", int_n, 0);
    do_ack(1);

    // R6: non-acknowledge strobe patterns
    set_strobes(0, 1, 0, 1); @(negedge clk);
    chk(bus_oe == 0, "R6 io read not ack", bus_oe, 0);
    set_strobes(1, 0, 0, 1); @(negedge clk);
    chk(bus_oe == 0, "R6 fetch not ack", bus_oe, 0);
    set_strobes(0, 0, 1, 0); @(negedge clk);
    chk(bus_oe == 0, "R6 write not ack", bus_oe, 0);
    set_strobes(1, 1, 1, 1);
    cycle();

    // R11: new edge at the end of its own acknowledge
    pulse(0, 1);
    set_strobes(0, 0, 1, 1); cycle();
    set_strobes(1, 1, 1, 1); rx_req = 1; cycle();
    rx_req = 0;
    chk(int_n == 0, "R11 new edge survives clear", int_n, 0);
    do_ack(1);
    chk(int_n == 1, "R11 served", int_n, 1);

    // random phase checked against the model every cycle
    begin
      int hold = 0;
      for (int i = 0; i < 4000; i++) begin
        logic [31:0] r;
        r = $urandom();
        if (r[2:0] == 3'd0) rx_req = ~rx_req;
        if (r[5:3] == 3'd0) tick_req = ~tick_req;
        cmd_valid = (r[8:6] == 3'd0);
        cmd_code  = (r[10:9] == 2'd0) ? 8'h0E : (r[10:9] == 2'd1) ? 8'h0F :
                    (r[10:9] == 2'd2) ? r[31:24] : 8'h0E;
        cmd_data  = r[18:11];
        if (hold > 0) hold--;
        else begin
          case (r[21:19])
            3'd0, 3'd1: begin set_strobes(0, 0, 1, 1); hold = int'(r[23:22]); end
            3'd2: set_strobes(0, 1, 0, 1);
            3'd3: set_strobes(1, 0, 0, 1);
            default: set_strobes(1, 1, 1, 1);
          endcase
        end
        cycle();
      end
      cmd_valid = 0;
      set_strobes(1, 1, 1, 1);
      cycle();
    end
    finish_run();
  end
endmodule